// File: doc/BRIEF.md
# Configurable Programmable Logic Cell

This block is one programmable logic cell of the kind tiled inside a reconfigurable fabric. A four-input look-up table (LUT) is defined by a 16-bit truth-table mask. A single storage element sits beside it and can behave as a D, T, JK or SR flip-flop. Three routed outputs each pick, on their own, the unregistered LUT result or the stored value. A static 32-bit configuration word, supplied on a port, sets every choice in the cell.

The register can be loaded from the LUT. It can also be loaded from an unrelated data pin, so the LUT and the register serve separate logic functions. A third source is a chain input from the neighbouring cell. A feedback option returns the stored bit to the top LUT index. An arithmetic option splits the mask into a sum half and a carry half and ripples the carry combinationally to the next cell. The configuration word selects one of two clocks and one of two enables. The register can be cleared asynchronously by either of two cluster clears or by the device-wide reset. That reset is released synchronously. Synchronous clear and synchronous load also act on the register.

Top module: `plc_cell`

## Requirements
- R1: With cfg[29]=0, every output whose select bit is 0 shows, without delay, mask bit cfg[idx], where idx={d[3],d[2],d[1],d[0]} and d[0] is the LSB. The mask occupies cfg[15:0].
- R2: cfg[23], cfg[24] and cfg[25] route out_loc, out_row and out_col respectively: 0 selects the LUT result and 1 selects the register. Each bit acts alone. chain_out always shows the register.
- R3: Flip-flop mode is cfg[31:30] (0=D, 1=T, 2=JK, 3=SR). Register source is cfg[27:26] (0=LUT, 1=chain_in, 2 or 3=rdata). In D mode with source LUT, the register takes the LUT result on an enabled clock edge, so the unregistered and registered LUT values are visible together.
- R4: In T mode the register inverts when the selected source bit is 1 and holds when it is 0.
- R5: In JK mode, J=d[0] and K=d[1]. The codes 10 and 01 set and reset the register, 00 holds it, and 11 inverts it.
- R6: In SR mode, S=d[0] and R=d[1]. 10 sets and 01 resets. Both 00 and 11 hold the register.
- R7: With source 2 or 3 (packing), the register loads rdata while the LUT computes its own function. Synchronous load is ignored in this mode.
- R8: With source 1, the register loads chain_in. The register is always presented on chain_out for the next cell.
- R9: With cfg[28]=1, the register value replaces d[3] as the top LUT index bit.
- R10: With cfg[29]=1, the LUT result is cfg[{0,cin,d[1],d[0]}] and cout is cfg[{1,cin,d[1],d[0]}], both without delay. With cfg[29]=0, cout equals cin.
- R11: Priority on a clock edge is: synchronous clear (sclr, when cfg[17]=1), then synchronous load of d[2] (sload, when cfg[16]=1), then the flip-flop mode. None of these acts unless the enable is active. The enable is always active when cfg[20]=0. When cfg[20]=1 it is ena1 if cfg[21]=1 and ena0 otherwise.
- R12: A low dev_rst_n clears the register at once. With cfg[19]=1, a high clr1 (if cfg[18]=1) or a high clr0 (if cfg[18]=0) also clears it at once. After dev_rst_n rises, the register stays clear through two edges of the selected clock and first updates on the third.
- R13: cfg[22]=1 clocks the register from clk1 and cfg[22]=0 from clk0. Edges on the clock that is not selected have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk0 | input | 1 | Cluster clock 0 |
| clk1 | input | 1 | Cluster clock 1 |
| dev_rst_n | input | 1 | Device-wide asynchronous reset, active low |
| clr0 | input | 1 | Cluster asynchronous clear 0, active high |
| clr1 | input | 1 | Cluster asynchronous clear 1, active high |
| ena0 | input | 1 | Cluster clock enable 0 |
| ena1 | input | 1 | Cluster clock enable 1 |
| sclr | input | 1 | Cluster synchronous clear |
| sload | input | 1 | Cluster synchronous load |
| cfg | input | 32 | Static configuration word |
| d | input | 4 | LUT data inputs |
| rdata | input | 1 | Register data for packing |
| chain_in | input | 1 | Register chain from previous cell |
| cin | input | 1 | Carry in |
| out_loc | output | 1 | Local routing output |
| out_row | output | 1 | Row routing output |
| out_col | output | 1 | Column routing output |
| chain_out | output | 1 | Register chain to next cell |
| cout | output | 1 | Carry out |

## Verification
The stored bit reaches chain_out, and any output routed to the register, on the cycle after the edge that wrote it. With feedback on, it also shows up in the LUT outputs. A wrong next-state choice for a mode, priority or data source is therefore visible within one clock. A wrong clear or reset-release count shows up as a nonzero register in the cycle where the requirements demand zero. A wrong carry or mask index differs on the combinational outputs in the same cycle as the input change.

// File: rtl/plc_pkg.sv
package plc_pkg;
  localparam int LUT_K  = 4;
  localparam int MASK_W = 1 << LUT_K;
  localparam int N_OUT  = 3;
  localparam int SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    FF_D  = 2'd0,
    FF_T  = 2'd1,
    FF_JK = 2'd2,
    FF_SR = 2'd3
  } ff_mode_e;

  typedef enum logic [1:0] {
    SRC_LUT   = 2'd0,
    SRC_CHAIN = 2'd1,
    SRC_PACK  = 2'd2,
    SRC_PACK2 = 2'd3
  } reg_src_e;

  typedef struct packed {
    ff_mode_e          ff_mode;
    logic              arith;
    logic              fb_en;
    reg_src_e          reg_src;
    logic [N_OUT-1:0]  out_reg;
    logic              clk_sel;
    logic              ena_sel;
    logic              ena_use;
    logic              clr_use;
    logic              clr_sel;
    logic              sclr_use;
    logic              sload_use;
    logic [MASK_W-1:0] mask;
  } cell_cfg_t;

  localparam int CFG_W = $bits(cell_cfg_t);
endpackage

// File: rtl/plc_lut.sv
module plc_lut
  import plc_pkg::*;
(
  input  logic [MASK_W-1:0] mask,
  input  logic [LUT_K-1:0]  d,
  input  logic              fb_en,
  input  logic              q,
  input  logic              arith,
  input  logic              cin,
  output logic              lut_o,
  output logic              cout
);
  localparam int AIDX_W = LUT_K - 1;

  logic [LUT_K-1:0]  idx;
  logic [AIDX_W-1:0] aidx;
  logic              norm_o;
  logic              sum_o;
  logic              carry_o;

  always_comb begin
    idx = d;
    if (fb_en) idx[LUT_K-1] = q;
  end

  assign norm_o  = mask[idx];
  assign aidx    = {cin, d[AIDX_W-2:0]};
  assign sum_o   = mask[{1'b0, aidx}];
  assign carry_o = mask[{1'b1, aidx}];

  assign lut_o = arith ? sum_o : norm_o;
  assign cout  = arith ? carry_o : cin;
endmodule

// File: rtl/plc_ctrl.sv
module plc_ctrl
  import plc_pkg::*;
(
  input  logic clk0,
  input  logic clk1,
  input  logic clk_sel,
  input  logic dev_rst_n,
  input  logic clr0,
  input  logic clr1,
  input  logic clr_use,
  input  logic clr_sel,
  input  logic ena0,
  input  logic ena1,
  input  logic ena_sel,
  input  logic ena_use,
  output logic clk_g,
  output logic rst_sync_n,
  output logic aclr_n,
  output logic ena
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   clr_hit;

  assign clk_g = clk_sel ? clk1 : clk0;

  assign sync_d = {sync_q[SYNC_STAGES-2:0], 1'b1};

  always_ff @(posedge clk_g or negedge dev_rst_n) begin
    if (!dev_rst_n) sync_q <= '0;
    else            sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[SYNC_STAGES-1];
  assign clr_hit    = clr_use & (clr_sel ? clr1 : clr0);
  assign aclr_n     = rst_sync_n & ~clr_hit;
  assign ena        = ena_use ? (ena_sel ? ena1 : ena0) : 1'b1;

  // R12: the stage feeding the output was low one edge ago, so the output is still low
  a_r12_release_hold: assert property (@(posedge clk_g) disable iff (!dev_rst_n)
    !$past(sync_q[SYNC_STAGES-2]) |-> !rst_sync_n);
endmodule

// File: rtl/plc_ff.sv
module plc_ff
  import plc_pkg::*;
(
  input  logic     clk,
  input  logic     aclr_n,
  input  logic     ena,
  input  ff_mode_e mode,
  input  logic     sclr,
  input  logic     sload,
  input  logic     sload_d,
  input  logic     din,
  input  logic     ctl_a,
  input  logic     ctl_b,
  output logic     q
);
  logic q_d;

  always_comb begin
    q_d = q;
    if (sclr) begin
      q_d = 1'b0;
    end else if (sload) begin
      q_d = sload_d;
    end else begin
      unique case (mode)
        FF_D: q_d = din;
        FF_T: q_d = q ^ din;
        FF_JK: begin
          case ({ctl_a, ctl_b})
            2'b10:   q_d = 1'b1;
            2'b01:   q_d = 1'b0;
            2'b11:   q_d = ~q;
            default: q_d = q;
          endcase
        end
        FF_SR: begin
          if (ctl_a && !ctl_b)      q_d = 1'b1;
          else if (ctl_b && !ctl_a) q_d = 1'b0;
          else                      q_d = q;
        end
        default: q_d = q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge aclr_n) begin
    if (!aclr_n)  q <= 1'b0;
    else if (ena) q <= q_d;
  end

  // R11: enabled synchronous clear wins over everything else
  a_r11_sclr_zero: assert property (@(posedge clk) disable iff (!aclr_n)
    (ena && sclr) |=> !q);

  // R11: no enable, no change
  a_r11_ena_gate: assert property (@(posedge clk) disable iff (!aclr_n)
    !ena |=> $stable(q));

  // R6: SR with both controls set keeps its state
  a_r6_sr_hold: assert property (@(posedge clk) disable iff (!aclr_n)
    (ena && !sclr && !sload && mode == FF_SR && ctl_a && ctl_b) |=> $stable(q));

  // R5: JK with both controls set inverts
  a_r5_jk_toggle: assert property (@(posedge clk) disable iff (!aclr_n)
    (ena && !sclr && !sload && mode == FF_JK && ctl_a && ctl_b) |=> (q != $past(q)));
endmodule

// File: rtl/plc_cell.sv
module plc_cell
  import plc_pkg::*;
(
  input  logic             clk0,
  input  logic             clk1,
  input  logic             dev_rst_n,
  input  logic             clr0,
  input  logic             clr1,
  input  logic             ena0,
  input  logic             ena1,
  input  logic             sclr,
  input  logic             sload,
  input  logic [31:0]      cfg,
  input  logic [3:0]       d,
  input  logic             rdata,
  input  logic             chain_in,
  input  logic             cin,
  output logic             out_loc,
  output logic             out_row,
  output logic             out_col,
  output logic             chain_out,
  output logic             cout
);
  cell_cfg_t        cfg_s;
  logic             clk_g;
  logic             rst_sync_n;
  logic             aclr_n;
  logic             ena;
  logic             lut_o;
  logic             q;
  logic             din;
  logic             packing;
  logic             sclr_eff;
  logic             sload_eff;
  logic [N_OUT-1:0] outs;

  assign cfg_s = cell_cfg_t'(cfg);

  plc_ctrl u_ctrl (
    .clk0       (clk0),
    .clk1       (clk1),
    .clk_sel    (cfg_s.clk_sel),
    .dev_rst_n  (dev_rst_n),
    .clr0       (clr0),
    .clr1       (clr1),
    .clr_use    (cfg_s.clr_use),
    .clr_sel    (cfg_s.clr_sel),
    .ena0       (ena0),
    .ena1       (ena1),
    .ena_sel    (cfg_s.ena_sel),
    .ena_use    (cfg_s.ena_use),
    .clk_g      (clk_g),
    .rst_sync_n (rst_sync_n),
    .aclr_n     (aclr_n),
    .ena        (ena)
  );

  plc_lut u_lut (
    .mask  (cfg_s.mask),
    .d     (d),
    .fb_en (cfg_s.fb_en),
    .q     (q),
    .arith (cfg_s.arith),
    .cin   (cin),
    .lut_o (lut_o),
    .cout  (cout)
  );

  assign packing = (cfg_s.reg_src == SRC_PACK) || (cfg_s.reg_src == SRC_PACK2);

  always_comb begin
    unique case (cfg_s.reg_src)
      SRC_LUT:   din = lut_o;
      SRC_CHAIN: din = chain_in;
      default:   din = rdata;
    endcase
  end

  assign sclr_eff  = cfg_s.sclr_use & sclr;
  assign sload_eff = cfg_s.sload_use & sload & ~packing;

  plc_ff u_ff (
    .clk     (clk_g),
    .aclr_n  (aclr_n),
    .ena     (ena),
    .mode    (cfg_s.ff_mode),
    .sclr    (sclr_eff),
    .sload   (sload_eff),
    .sload_d (d[2]),
    .din     (din),
    .ctl_a   (d[0]),
    .ctl_b   (d[1]),
    .q       (q)
  );

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    assign outs[g] = cfg_s.out_reg[g] ? q : lut_o;
  end

  assign out_loc   = outs[0];
  assign out_row   = outs[1];
  assign out_col   = outs[2];
  assign chain_out = q;

  // R7: packed D register follows rdata, synchronous load has no say
  a_r7_pack_load: assert property (@(posedge clk_g) disable iff (!aclr_n)
    (packing && ena && !sclr_eff && cfg_s.ff_mode == FF_D) |=> (chain_out == $past(rdata)));

  // R8: chain source feeds the next cell one edge later
  a_r8_chain_load: assert property (@(posedge clk_g) disable iff (!aclr_n)
    (cfg_s.reg_src == SRC_CHAIN && ena && !sclr_eff && !sload_eff && cfg_s.ff_mode == FF_D)
      |=> (chain_out == $past(chain_in)));

  // R12: a held clear keeps the register at zero
  a_r12_clear_zero: assert property (@(posedge clk_g) disable iff (!rst_sync_n)
    !aclr_n |-> !chain_out);
endmodule

// File: tb/test_plc_cell.sv
`timescale 1ns/1ps
module test_plc_cell;
  logic        clk0 = 1'b0;
  logic        clk1_run = 1'b0;
  logic        clk1;
  logic        dev_rst_n, clr0, clr1, ena0, ena1, sclr, sload;
  logic [31:0] cfg;
  logic [3:0]  d;
  logic        rdata, chain_in, cin;
  logic        out_loc, out_row, out_col, chain_out, cout;

  int    errors = 0;
  int    checks = 0;
  string cur_req = "R12";
  bit    chk_on = 1'b0;
  bit    allow_clr = 1'b0;
  logic  m_q = 1'b0;
  int    m_rel = 0;

  always #10 clk0 = ~clk0;
  assign clk1 = clk0 & clk1_run;

  plc_cell i_plc_cell (
    .clk0(clk0), .clk1(clk1), .dev_rst_n(dev_rst_n), .clr0(clr0), .clr1(clr1),
    .ena0(ena0), .ena1(ena1), .sclr(sclr), .sload(sload), .cfg(cfg), .d(d),
    .rdata(rdata), .chain_in(chain_in), .cin(cin), .out_loc(out_loc),
    .out_row(out_row), .out_col(out_col), .chain_out(chain_out), .cout(cout)
  );

  function automatic logic [31:0] mk(int mode, bit ar, bit fb, int src, logic [2:0] orr,
                                     bit cks, bit es, bit eu, bit cu, bit cs, bit su, bit lu,
                                     logic [15:0] m);
    return {2'(mode), ar, fb, 2'(src), orr, cks, es, eu, cu, cs, su, lu, m};
  endfunction

  // R1, R9, R10: behavioural truth-table lookup
  function automatic logic f_lut(logic qv);
    int i;
    if (cfg[29]) begin
      i = cin * 4 + d[1] * 2 + d[0];
      return cfg[i];
    end
    i = d[2] * 4 + d[1] * 2 + d[0];
    if (cfg[28]) i = i + qv * 8;
    else         i = i + d[3] * 8;
    return cfg[i];
  endfunction

  function automatic logic f_cout();
    if (cfg[29]) return cfg[8 + cin * 4 + d[1] * 2 + d[0]];
    return cin;
  endfunction

  function automatic logic f_clr_hit();
    return cfg[19] && (cfg[18] ? clr1 : clr0);
  endfunction

  function automatic logic f_next();
    logic en, src_bit;
    int   mode;
    en = !cfg[20] || (cfg[21] ? ena1 : ena0);
    if (!en) return m_q;
    if (cfg[17] && sclr) return 1'b0;
    if (cfg[16] && sload && !cfg[27]) return d[2];
    case (cfg[27:26])
      2'd0:    src_bit = f_lut(m_q);
      2'd1:    src_bit = chain_in;
      default: src_bit = rdata;
    endcase
    mode = cfg[31:30];
    case (mode)
      0: return src_bit;
      1: return src_bit ? !m_q : m_q;
      2: begin
        if (d[0] && d[1]) return !m_q;
        if (d[0]) return 1'b1;
        if (d[1]) return 1'b0;
        return m_q;
      end
      default: begin
        if (d[0] && !d[1]) return 1'b1;
        if (d[1] && !d[0]) return 1'b0;
        return m_q;
      end
    endcase
  endfunction

  // reference model advances on each edge of the selected clock (R13)
  always @(posedge clk0) begin
    if (!(cfg[22] && !clk1_run)) begin
      if (!dev_rst_n) begin
        m_rel = 0;
        m_q = 1'b0;
      end else begin
        if (f_clr_hit())    m_q = 1'b0;
        else if (m_rel >= 2) m_q = f_next();
        if (m_rel < 2) m_rel++;
      end
    end
  end

  task automatic cmp(string name, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", cur_req, name, act, exp);
    end
  endtask

  always @(negedge clk0) begin
    logic lv;
    if (!dev_rst_n) begin
      m_rel = 0;
      m_q = 1'b0;
    end
    if (f_clr_hit()) m_q = 1'b0;
    if (chk_on) begin
      lv = f_lut(m_q);
      cmp("out_loc", out_loc, cfg[23] ? m_q : lv);
      cmp("out_row", out_row, cfg[24] ? m_q : lv);
      cmp("out_col", out_col, cfg[25] ? m_q : lv);
      cmp("chain_out", chain_out, m_q);
      cmp("cout", cout, f_cout());
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  task automatic drive_rand();
    d        = 4'($urandom);
    rdata    = 1'($urandom);
    chain_in = 1'($urandom);
    cin      = 1'($urandom);
    ena0     = 1'($urandom);
    ena1     = 1'($urandom);
    sclr     = ($urandom % 4) == 0;
    sload    = ($urandom % 3) == 0;
    clr0     = allow_clr && (($urandom % 8) == 0);
    clr1     = allow_clr && (($urandom % 8) == 0);
  endtask

  task automatic run(string req, logic [31:0] c, int n);
    @(negedge clk0); #5;
    cur_req = req;
    cfg = c;
    drive_rand();
    for (int k = 1; k < n; k++) begin
      @(negedge clk0); #5;
      drive_rand();
    end
  endtask

  initial begin
    logic [15:0] add_m;
    for (int i = 0; i < 8; i++) begin
      add_m[i]     = i[0] ^ i[1] ^ i[2];
      add_m[8 + i] = (i[0] & i[1]) | (i[0] & i[2]) | (i[1] & i[2]);
    end
    dev_rst_n = 1'b1; clr0 = 0; clr1 = 0; ena0 = 0; ena1 = 0; sclr = 0; sload = 0;
    d = 0; rdata = 0; chain_in = 0; cin = 0;
    cfg = mk(0, 0, 0, 0, 3'b111, 0, 0, 0, 0, 0, 0, 0, 16'h6996);
    #1 dev_rst_n = 1'b0;
    @(negedge clk0); #5;
    chk_on = 1'b1;
    // R12: reset state, then two-edge release hold
    repeat (3) begin @(negedge clk0); #5; drive_rand(); end
    dev_rst_n = 1'b1;
    run("R12", mk(0, 0, 0, 0, 3'b111, 0, 0, 0, 0, 0, 0, 0, 16'h6996), 8);
    run("R1",  mk(0, 0, 0, 0, 3'b000, 0, 0, 0, 0, 0, 0, 0, 16'hA5C3), 24);
    run("R3",  mk(0, 0, 0, 0, 3'b101, 0, 0, 0, 0, 0, 0, 0, 16'h1E78), 24);
    for (int o = 0; o < 8; o++)
      run("R2", mk(0, 0, 0, 2, 3'(o), 0, 0, 0, 0, 0, 0, 0, 16'hF00F), 5);
    run("R4",  mk(1, 0, 0, 2, 3'b010, 0, 0, 0, 0, 0, 0, 0, 16'h0FF0), 24);
    run("R4",  mk(1, 0, 0, 0, 3'b010, 0, 0, 0, 0, 0, 0, 0, 16'h8001), 16);
    run("R5",  mk(2, 0, 0, 0, 3'b100, 0, 0, 0, 0, 0, 0, 0, 16'h3C3C), 32);
    run("R6",  mk(3, 0, 0, 0, 3'b001, 0, 0, 0, 0, 0, 0, 0, 16'hC3C3), 32);
    run("R7",  mk(0, 0, 0, 2, 3'b110, 0, 0, 0, 0, 0, 0, 1, 16'h7E81), 24);
    run("R7",  mk(0, 0, 0, 3, 3'b011, 0, 0, 0, 0, 0, 0, 1, 16'h4B2D), 16);
    run("R8",  mk(0, 0, 0, 1, 3'b000, 0, 0, 0, 0, 0, 0, 0, 16'h9999), 24);
    run("R9",  mk(0, 0, 1, 0, 3'b000, 0, 0, 0, 0, 0, 0, 0, 16'h5AC3), 32);
    run("R10", mk(0, 1, 0, 0, 3'b001, 0, 0, 0, 0, 0, 0, 0, add_m), 24);
    run("R10", mk(0, 1, 0, 0, 3'b000, 0, 0, 0, 0, 0, 0, 0, 16'hD2B4), 16);
    run("R11", mk(0, 0, 0, 0, 3'b111, 0, 0, 1, 0, 0, 1, 1, 16'h6C39), 32);
    run("R11", mk(2, 0, 0, 0, 3'b111, 0, 1, 1, 0, 0, 1, 1, 16'h6C39), 32);
    run("R11", mk(3, 0, 0, 1, 3'b111, 0, 0, 0, 0, 0, 1, 1, 16'h6C39), 24);
    allow_clr = 1'b1;
    run("R12", mk(1, 0, 0, 2, 3'b111, 0, 0, 0, 1, 1, 0, 0, 16'h0000), 24);
    run("R12", mk(0, 0, 0, 1, 3'b111, 0, 0, 0, 1, 0, 0, 0, 16'h0000), 24);
    allow_clr = 1'b0;
    @(negedge clk0); #5;
    dev_rst_n = 1'b0;
    drive_rand();
    @(negedge clk0); #5;
    dev_rst_n = 1'b1;
    run("R12", mk(0, 0, 0, 2, 3'b111, 0, 0, 0, 0, 0, 0, 0, 16'h0000), 8);
    // R13: register follows clk1 only when it runs
    for (int k = 0; k < 6; k++) begin
      clk1_run = k[0];
      run("R13", mk(0, 0, 0, 2, 3'b111, 1, 0, 0, 0, 0, 0, 0, 16'h1234), 6);
    end
    clk1_run = 1'b0;
    run("R13", mk(0, 0, 0, 2, 3'b111, 0, 0, 0, 0, 0, 0, 0, 16'h1234), 6);
    @(negedge clk0); #5;
    chk_on = 1'b0;
    summary();
    $finish;
  end
endmodule